// File: doc/BRIEF.md
# SPI Direct-Write Window Engine

This block turns ordinary bus stores into SPI transmit bytes. The address space is split into fixed-size regions. Region 0 holds a single configuration register. Each region from 1 to `NUM_CS` is a write-only window that belongs to one chip select: region k drives chip select k-1. When a store lands in a window, the bytes enabled by its strobes go out on a byte-stream interface toward an SPI shifter, in ascending lane order, and that window's chip select is asserted for the whole transfer. A full 32-bit store therefore yields four bytes, lowest lane first. A single-byte store yields one byte.

Software builds a long transfer from a run of word stores followed by one to three byte stores, all aimed at the start of the same window. Bit 0 of the configuration register sets the chip-select policy:

- With bit 0 at 0 (hold), chip select stays asserted between stores.
- With bit 0 at 1 (release), chip select drops when each store finishes.

While bytes from one store are still being handed off, the block holds the bus ready low. This stalls the next store, whether it is a window store or a configuration write.

Top module: `spi_dw_window`

## Requirements
- R1: After a synchronous reset, every `cs_n` bit is 1, `tx_valid` is 0 and `bus_wr_ready` is 1. The configuration returns to hold (bit 0 = 0), including after a reset that occurs while a chip select is held.
- R2: A store to address region k, where 1 <= k <= NUM_CS and the region is `addr[ADDR_W-1:WIN_SHIFT]`, transmits on chip select k-1. For every byte of that store, `cs_n` is all ones except bit k-1, which is 0.
- R3: A store with strobes 4'b1111 sends four bytes in this order: data[7:0], data[15:8], data[23:16], data[31:24].
- R4: A store with a partial strobe pattern sends only the enabled lanes, in ascending lane order.
- R5: The address bits below WIN_SHIFT inside a window have no effect on the bytes or on the chip select.
- R6: `bus_wr_ready` is 0 from the cycle after a window store is accepted until the edge that hands off its last byte. A store presented during that time produces no byte until all earlier bytes are out.
- R7: In hold mode, the chip select stays asserted after a store completes and across further stores to the same window.
- R8: In release mode, `cs_n` returns to all ones on the same clock edge that hands off the last byte of the store.
- R9: Writing 1 to bit 0 of the configuration register (region 0, offset 0x20, strobe 0 set) while a chip select is held in hold mode releases it on the edge that accepts the write.
- R10: At most one `cs_n` bit is ever 0. A store to a different window while another chip select is held moves the assertion directly to the new chip select.
- R11: Three kinds of store are accepted but ignored: a window store with all strobes 0, a region-0 store to any offset other than 0x20, and a store to a region above NUM_CS. None of them produces a byte or changes `cs_n`.
- R12: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` is held steady on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_valid | input | 1 | Bus store request |
| bus_wr_addr | input | ADDR_W | Store byte address (region in top bits) |
| bus_wr_data | input | 32 | Store data, lane 0 in bits 7:0 |
| bus_wr_strb | input | 4 | Byte-lane enables |
| bus_wr_ready | output | 1 | Store accepted when high with valid |
| tx_valid | output | 1 | A transmit byte is offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Shifter takes the byte |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench checks lane order with a full word and then with sparse strobe patterns. A design that picked lanes by priority from the top, or that counted bytes instead of masking them, would reorder the bytes or send disabled lanes.

It also stalls the shifter while a second store is already waiting. A design without the ready interlock would overwrite bytes still queued for transmission, and one that changed data under backpressure would corrupt the byte on the wire.

The chip-select policy is probed at the exact edge of the last byte, on a configuration write made while a chip select is held, on a switch between windows in hold mode, and on reset during hold. A design that got these wrong would show a lingering or dropped select, two selects asserted at once, or a stale release setting after reset.

Finally, strobe-less stores, unmapped offsets and out-of-range regions must leave both the byte stream and the selects untouched.

// File: rtl/spi_dw_pkg.sv
// Shared types for the SPI direct-write window engine.
package spi_dw_pkg;
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_WIN  = 2'd1,
        REQ_CFG  = 2'd2
    } req_kind_t;
endpackage

// File: rtl/spi_dw_decode.sv
// Address decoder: classifies a bus store as a window store, a configuration
// write or an ignored access, and derives the target chip select.
// Assumes region 0 is the register space and regions 1..NUM_CS are windows.
module spi_dw_decode
    import spi_dw_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WIN_SHIFT = 12,
    parameter int NUM_CS    = 8,
    parameter int CFG_OFS   = 32'h20,
    parameter int LANES     = 4,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int REG_W    = ADDR_W - WIN_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  strb,
    output req_kind_t         kind,
    output logic [CS_W-1:0]   cs_idx
);
    logic [REG_W-1:0] region;
    logic             in_win;
    logic             at_cfg;

    assign region = addr[ADDR_W-1:WIN_SHIFT];
    assign in_win = (32'(region) >= 32'd1) && (32'(region) <= 32'(NUM_CS));
    assign at_cfg = (region == '0) &&
                    (addr[WIN_SHIFT-1:0] == WIN_SHIFT'(CFG_OFS)) && strb[0];
    assign cs_idx = CS_W'(32'(region) - 32'd1);

    // Pick the request kind; strobe-less window stores are dropped.
    always_comb begin
        if (in_win && (strb != '0)) kind = REQ_WIN;
        else if (at_cfg)            kind = REQ_CFG;
        else                        kind = REQ_NONE;
    end
endmodule

// File: rtl/spi_dw_lane_seq.sv
// Lane sequencer: holds one accepted store and offers its enabled byte
// lanes, lowest first, on a valid/ready byte stream.
// Assumes load is only raised while the sequencer is empty.
module spi_dw_lane_seq #(
    parameter int LANES   = 4,
    localparam int DATA_W = LANES * 8,
    localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [LANES-1:0]  load_strb,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              last_take
);
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] data_q;
    logic [LIDX_W-1:0] idx;
    logic [LANES-1:0]  rest;

    // Find the lowest lane still pending.
    always_comb begin
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask_q[i]) idx = LIDX_W'(i);
        end
    end

    assign rest      = mask_q & ~(LANES'(1) << idx);
    assign tx_valid  = |mask_q;
    assign tx_data   = data_q[{idx, 3'b000} +: 8];
    assign last_take = tx_valid && tx_ready && (rest == '0);

    // Capture a new store or retire the lane just handed off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            data_q <= '0;
        end else if (load) begin
            mask_q <= load_strb;
            data_q <= load_data;
        end else if (tx_valid && tx_ready) begin
            mask_q <= rest;
        end
    end
endmodule

// File: rtl/spi_dw_cs_ctrl.sv
// Chip-select controller: keeps the hold/release setting and drives one
// active-low select for the window being written.
// Assumes cfg_wr and start never coincide.
module spi_dw_cs_ctrl #(
    parameter int NUM_CS = 8,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_release,
    input  logic              start,
    input  logic [CS_W-1:0]   start_cs,
    input  logic              done,
    output logic [NUM_CS-1:0] cs_n
);
    logic            rel_q;
    logic            on_q;
    logic [CS_W-1:0] sel_q;

    // Track the policy bit and whether a select is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q <= 1'b0;
            on_q  <= 1'b0;
            sel_q <= '0;
        end else if (cfg_wr) begin
            rel_q <= cfg_release;
            if (cfg_release) on_q <= 1'b0;
        end else if (start) begin
            on_q  <= 1'b1;
            sel_q <= start_cs;
        end else if (done && rel_q) begin
            on_q  <= 1'b0;
        end
    end

    // One output per chip select.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(on_q && (sel_q == CS_W'(g)));
    end
endmodule

// File: rtl/spi_dw_window.sv
// Top of the direct-write window engine: accepts bus stores, routes window
// stores to the lane sequencer and drives the owning chip select.
// Assumes one outstanding store at a time; ready stalls all further stores.
module spi_dw_window
    import spi_dw_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WIN_SHIFT = 12,
    parameter int NUM_CS    = 8,
    parameter int CFG_OFS   = 32'h20,
    localparam int LANES    = 4,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_valid,
    input  logic [ADDR_W-1:0] bus_wr_addr,
    input  logic [31:0]       bus_wr_data,
    input  logic [3:0]        bus_wr_strb,
    output logic              bus_wr_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic [NUM_CS-1:0] cs_n
);
    req_kind_t       kind;
    logic [CS_W-1:0] cs_idx;
    logic            accept;
    logic            last_take;

    assign bus_wr_ready = !tx_valid;
    assign accept       = bus_wr_valid && bus_wr_ready;

    spi_dw_decode #(
        .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .NUM_CS(NUM_CS),
        .CFG_OFS(CFG_OFS), .LANES(LANES)
    ) u_decode (
        .addr(bus_wr_addr), .strb(bus_wr_strb), .kind(kind), .cs_idx(cs_idx)
    );

    spi_dw_lane_seq #(.LANES(LANES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .load(accept && (kind == REQ_WIN)),
        .load_data(bus_wr_data), .load_strb(bus_wr_strb),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .last_take(last_take)
    );

    spi_dw_cs_ctrl #(.NUM_CS(NUM_CS)) u_cs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(accept && (kind == REQ_CFG)), .cfg_release(bus_wr_data[0]),
        .start(accept && (kind == REQ_WIN)), .start_cs(cs_idx),
        .done(last_take), .cs_n(cs_n)
    );
endmodule

// File: rtl/spi_dw_window_chk.sv
// Checker for the direct-write window engine, bound to the top module.
module spi_dw_window_chk #(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic [NUM_CS-1:0] cs_n
);
    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R10
    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R12
    AST_STALL_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !bus_wr_ready); // R6
    AST_CS_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (cs_n != '1)); // R2
    AST_CS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(tx_valid)) |-> $stable(cs_n)); // R7
endmodule

bind spi_dw_window spi_dw_window_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr_ready(bus_wr_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .cs_n(cs_n)
);

// File: tb/test_spi_dw_window.sv
`timescale 1ns/1ps
module test_spi_dw_window;
    localparam int NCS = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr_valid = 1'b0;
    logic [15:0]     bus_wr_addr = '0;
    logic [31:0]     bus_wr_data = '0;
    logic [3:0]      bus_wr_strb = '0;
    logic            bus_wr_ready;
    logic            tx_valid;
    logic [7:0]      tx_data;
    logic            tx_ready = 1'b1;
    logic [NCS-1:0]  cs_n;

    int checks = 0;
    int fails  = 0;
    logic [7:0]     cap_data [0:255];
    logic [NCS-1:0] cap_csn  [0:255];
    int cap_n = 0;

    always #4 clk = ~clk;

    spi_dw_window i_spi_dw_window (
        .clk(clk), .rst_n(rst_n), .bus_wr_valid(bus_wr_valid),
        .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
        .bus_wr_strb(bus_wr_strb), .bus_wr_ready(bus_wr_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .cs_n(cs_n)
    );

    // Record every byte that will be handed off at the next rising edge.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready && cap_n < 256) begin
            cap_data[cap_n] = tx_data;
            cap_csn[cap_n]  = cs_n;
            cap_n++;
        end
    end

    function automatic logic [NCS-1:0] sel(input int c);
        return ~(NCS'(1) << c);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive_store(input logic [15:0] a, input logic [31:0] d,
                               input logic [3:0] s);
        @(posedge clk); #2;
        bus_wr_valid = 1'b1; bus_wr_addr = a; bus_wr_data = d; bus_wr_strb = s;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (bus_wr_ready) break;
        end
        @(posedge clk); #2;
        bus_wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!tx_valid) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "cs_n after reset", 32'(cs_n), 32'(sel(NCS)));
        chk("R1", "tx_valid after reset", 32'(tx_valid), 32'd0);
        chk("R1", "ready after reset", 32'(bus_wr_ready), 32'd1);
    endtask

    task automatic t_word();
        int b = cap_n;
        drive_store(16'h3000, 32'hA1B2C3D4, 4'hF);
        wait_idle();
        chk("R3", "byte count", 32'(cap_n - b), 32'd4);
        chk("R3", "byte0", 32'(cap_data[b]),   32'hD4);
        chk("R3", "byte1", 32'(cap_data[b+1]), 32'hC3);
        chk("R3", "byte2", 32'(cap_data[b+2]), 32'hB2);
        chk("R3", "byte3", 32'(cap_data[b+3]), 32'hA1);
        chk("R2", "cs during bytes", 32'(cap_csn[b+3]), 32'(sel(2)));
        chk("R7", "cs held after store", 32'(cs_n), 32'(sel(2)));
    endtask

    task automatic t_partial();
        int b = cap_n;
        drive_store(16'h3ABC, 32'h11223344, 4'b1010);
        wait_idle();
        chk("R4", "byte count", 32'(cap_n - b), 32'd2);
        chk("R4", "first lane", 32'(cap_data[b]),   32'h33);
        chk("R4", "second lane", 32'(cap_data[b+1]), 32'h11);
        chk("R5", "offset ignored cs", 32'(cap_csn[b]), 32'(sel(2)));
        chk("R7", "cs held across stores", 32'(cs_n), 32'(sel(2)));
    endtask

    task automatic t_backpressure();
        int b = cap_n;
        tx_ready = 1'b0;
        drive_store(16'h1000, 32'h55667788, 4'hF);
        repeat (3) begin
            @(negedge clk);
            chk("R12", "byte held", 32'(tx_data), 32'h88);
            chk("R6", "ready low while busy", 32'(bus_wr_ready), 32'd0);
        end
        fork
            drive_store(16'h1000, 32'h000099AA, 4'b0011);
            begin
                repeat (3) @(posedge clk);
                #2 tx_ready = 1'b1;
            end
        join
        wait_idle();
        chk("R6", "byte count", 32'(cap_n - b), 32'd6);
        chk("R6", "first store last", 32'(cap_data[b+3]), 32'h55);
        chk("R6", "second store first", 32'(cap_data[b+4]), 32'hAA);
        chk("R6", "second store second", 32'(cap_data[b+5]), 32'h99);
        chk("R10", "switched cs", 32'(cap_csn[b]), 32'(sel(0)));
        chk("R10", "only new cs held", 32'(cs_n), 32'(sel(0)));
    endtask

    task automatic t_ignore();
        int b = cap_n;
        logic [NCS-1:0] c0 = cs_n;
        drive_store(16'h2000, 32'hDEADBEEF, 4'b0000);
        drive_store(16'h0010, 32'h00000001, 4'hF);
        drive_store(16'h9000, 32'hCAFEF00D, 4'hF);
        repeat (3) @(negedge clk);
        chk("R11", "no bytes", 32'(cap_n - b), 32'd0);
        chk("R11", "cs unchanged", 32'(cs_n), 32'(c0));
    endtask

    task automatic t_cfg_release();
        drive_store(16'h0020, 32'h00000001, 4'b0001);
        @(negedge clk);
        chk("R9", "release on cfg write", 32'(cs_n), 32'(sel(NCS)));
    endtask

    task automatic t_release_mode();
        int b = cap_n;
        drive_store(16'h5000, 32'h0000005A, 4'b0001);
        wait_idle();
        chk("R8", "byte", 32'(cap_data[b]), 32'h5A);
        chk("R2", "cs for window 5", 32'(cap_csn[b]), 32'(sel(4)));
        chk("R8", "cs dropped at last byte", 32'(cs_n), 32'(sel(NCS)));
    endtask

    task automatic t_hold_reset();
        int b;
        drive_store(16'h0020, 32'h00000000, 4'b0001);
        drive_store(16'h4000, 32'h000000C1, 4'b0001);
        wait_idle();
        chk("R7", "hold after byte", 32'(cs_n), 32'(sel(3)));
        @(posedge clk); #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset releases cs", 32'(cs_n), 32'(sel(NCS)));
        b = cap_n;
        drive_store(16'h4000, 32'h0000E700, 4'b0010);
        wait_idle();
        chk("R1", "byte after reset", 32'(cap_data[b]), 32'hE7);
        chk("R1", "hold is reset default", 32'(cs_n), 32'(sel(3)));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_word();
        t_partial();
        t_backpressure();
        t_ignore();
        t_cfg_release();
        t_release_mode();
        t_hold_reset();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end
endmodule